// File: doc/BRIEF.md
# Dithered 8-bit DAC Code Generator

This block turns a 16-bit sample into an 8-bit code for a coarse DAC, producing a fresh code every system clock. The high byte of the sample is the base level. The low byte is a fraction, and it is delivered by switching the output between the base level and one step above it. The fraction of clocks spent one step above the base follows the low byte.

Two dither schemes can be selected at run time:
- **Random:** each clock, the low byte is compared with eight bits of a free-running pseudo-random sequence.
- **PWM:** a 256-clock frame carries a single run of raised clocks at its head.

Software hands samples over through a holding register. A programmable sample timer moves the held sample into the active register at each period boundary. A ready flag tells software when the holding register may be written again.

Top module: `dither_dac_gen`

## Requirements
- R1: The output code is always either the base (sample bits 15:8) or the raised level. The raised level is base+1, or 255 when the base is 255.
- R2: With mode_sel=0 (random), the output is raised on a clock when the low byte (sample bits 7:0) is greater than the low 8 bits of a pseudo-random value. Over many clocks, the raised fraction is close to low/256.
- R3: When the low byte is 0, the output equals the base on every clock in both modes.
- R4: With mode_sel=1 (PWM) and period 256, the first `low` output clocks of each frame are raised and the remaining 256-`low` clocks are at the base.
- R5: The PWM frame position restarts at every period boundary. With period 32, each period therefore shows min(low,32) raised clocks followed by base clocks, and operation continues normally.
- R6: A sample written away from a boundary is held and becomes active at the next period boundary. A second write before that boundary replaces the held value. A write on a boundary clock becomes active at once.
- R7: buf_ready falls on the clock after a write that is not on a boundary clock. It rises at the next period boundary.
- R8: A period of 1 makes buffering transparent: a write shows on dac_code two clocks after it is strobed, and buf_ready stays high. A period of 0 behaves as a period of 1.
- R9: When the base is 255, the output is 255 on every clock in both modes and never wraps.
- R10: After reset, dac_code is 0, buf_ready is 1, and the active sample is 0.
- R11: The pseudo-random source is a maximal-length 16-bit LFSR, advanced every clock from a nonzero seed. It never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Dither scheme: 0 random, 1 PWM |
| period | input | 16 | Sample period in system clocks (0 treated as 1) |
| wr_data | input | 16 | Sample written by software |
| wr_en | input | 1 | Write strobe for wr_data |
| dac_code | output | 8 | Registered code for the coarse DAC |
| buf_ready | output | 1 | High when the holding register is free |

## Verification
The bench builds the block with its default parameters: a 16-bit sample, an 8-bit code, a 16-bit period field and a 16-bit LFSR. It changes the period at run time across 0, 1, 32 and 256. This brings every case within reach: the transparent case, a short period that cuts the PWM frame, and full frames. The saturating top level, the zero-fraction hold and the overwrite of a pending sample are also exercised. Random-mode duty is judged statistically over several thousand clocks, because the exact sequence belongs to the design.

// File: rtl/dac_dither_pkg.sv
package dac_dither_pkg;

  typedef enum logic {
    DITHER_RANDOM = 1'b0,
    DITHER_PWM    = 1'b1
  } dither_mode_e;

endpackage

// File: rtl/dac_lfsr.sv
module dac_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] TAP_MASK  = TAPS[WIDTH-1:0];
  localparam logic [WIDTH-1:0] SEED_VAL  = SEED[WIDTH-1:0];
  localparam logic [WIDTH-1:0] ZERO_MASK = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED_VAL;
    end else begin
      state <= (state >> 1) ^ (state[0] ? TAP_MASK : ZERO_MASK);
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R11

endmodule

// File: rtl/dac_sample_buffer.sv
module dac_sample_buffer #(
  parameter int SAMPLE_W = 16,
  parameter int PERIOD_W = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                wr_en,
  output logic [SAMPLE_W-1:0] active_sample,
  output logic [FRAC_W-1:0]   frame_pos,
  output logic                buf_ready
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] tick;
  logic [SAMPLE_W-1:0] pending;
  logic                boundary;

  // A period of 0 or 1 makes every clock a boundary; >= keeps a shrunk period from stalling.
  assign boundary = (period <= ONE) || (tick >= period - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick          <= '0;
      frame_pos     <= '0;
      active_sample <= '0;
      pending       <= '0;
      buf_ready     <= 1'b1;
    end else begin
      tick      <= boundary ? '0 : tick + ONE;
      frame_pos <= boundary ? '0 : frame_pos + 1'b1;
      if (boundary) begin
        if (wr_en) begin
          active_sample <= wr_data;
        end else if (!buf_ready) begin
          active_sample <= pending;
        end
        buf_ready <= 1'b1;
      end else if (wr_en) begin
        pending   <= wr_data;
        buf_ready <= 1'b0;
      end
    end
  end

  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !boundary) |=> !buf_ready); // R7

  AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
    boundary |=> buf_ready); // R7

  AST_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (boundary && !wr_en && !buf_ready) |=> (active_sample == $past(pending))); // R6

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(active_sample)); // R6

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (frame_pos == '0)); // R5

endmodule

// File: rtl/dac_dither_mixer.sv
module dac_dither_mixer
  import dac_dither_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 8,
  parameter int RAND_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_sel,
  input  logic [SAMPLE_W-1:0] active_sample,
  input  logic [SAMPLE_W-CODE_W-1:0] frame_pos,
  input  logic [RAND_W-1:0]   rnd,
  output logic [CODE_W-1:0]   dac_code
);

  localparam int FRAC_W = SAMPLE_W - CODE_W;

  dither_mode_e      mode;
  logic [CODE_W-1:0] base;
  logic [CODE_W-1:0] raised;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] rnd_low;
  logic              lift;

  assign mode    = dither_mode_e'(mode_sel);
  assign base    = active_sample[SAMPLE_W-1:FRAC_W];
  assign frac    = active_sample[FRAC_W-1:0];
  assign rnd_low = rnd[FRAC_W-1:0];
  assign raised  = (base == '1) ? base : base + 1'b1;

  always_comb begin
    if (mode == DITHER_PWM) begin
      lift = frame_pos < frac;
    end else begin
      lift = frac > rnd_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
    end else begin
      dac_code <= lift ? raised : base;
    end
  end

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dac_code == $past(base)) || (dac_code == $past(base) + 1'b1))); // R1

  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (rst)
    (frac == '0) |=> (dac_code == $past(base))); // R3

  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (base == '1) |=> (dac_code == '1)); // R9

  AST_PWM_HEAD: assert property (@(posedge clk) disable iff (rst)
    (mode == DITHER_PWM && frac != '0 && frame_pos == '0 && base != '1)
      |=> (dac_code == $past(base) + 1'b1)); // R4

endmodule

// File: rtl/dither_dac_gen.sv
module dither_dac_gen #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 8,
  parameter int PERIOD_W = 16,
  parameter int LFSR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_sel,
  input  logic [PERIOD_W-1:0] period,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                wr_en,
  output logic [CODE_W-1:0]   dac_code,
  output logic                buf_ready
);

  localparam int FRAC_W = SAMPLE_W - CODE_W;

  logic [LFSR_W-1:0]   rnd;
  logic [SAMPLE_W-1:0] active_sample;
  logic [FRAC_W-1:0]   frame_pos;

  dac_lfsr #(
    .WIDTH (LFSR_W)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .state (rnd)
  );

  dac_sample_buffer #(
    .SAMPLE_W (SAMPLE_W),
    .PERIOD_W (PERIOD_W),
    .FRAC_W   (FRAC_W)
  ) u_buffer (
    .clk           (clk),
    .rst           (rst),
    .period        (period),
    .wr_data       (wr_data),
    .wr_en         (wr_en),
    .active_sample (active_sample),
    .frame_pos     (frame_pos),
    .buf_ready     (buf_ready)
  );

  dac_dither_mixer #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .RAND_W   (LFSR_W)
  ) u_mixer (
    .clk           (clk),
    .rst           (rst),
    .mode_sel      (mode_sel),
    .active_sample (active_sample),
    .frame_pos     (frame_pos),
    .rnd           (rnd),
    .dac_code      (dac_code)
  );

endmodule

// File: tb/dither_dac_gen_test.sv
module dither_dac_gen_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b0;
  logic [15:0] period = 16'd256;
  logic [15:0] wr_data = 16'h0000;
  logic        wr_en = 1'b0;
  logic [7:0]  dac_code;
  logic        buf_ready;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dither_dac_gen uut (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .period    (period),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .dac_code  (dac_code),
    .buf_ready (buf_ready)
  );

  function automatic logic [7:0] raised_of(input logic [15:0] s);
    return (s[15:8] == 8'hFF) ? 8'hFF : s[15:8] + 8'd1;
  endfunction

  function automatic logic [7:0] pwm_expect(input logic [15:0] s, input int pos);
    return (pos < int'(s[7:0])) ? raised_of(s) : s[15:8];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write a sample, then return at the negedge after the first clock that shows it.
  task automatic write_sync(input logic [15:0] s);
    @(negedge clk);
    wr_data = s;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (!buf_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_pwm_window(input logic [15:0] s, input int per, input int n, input string req);
    int errs = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = pwm_expect(s, i % per);
      if (dac_code !== e && errs == 0) begin
        first_act = dac_code;
        first_exp = e;
      end
      if (dac_code !== e) errs++;
      @(negedge clk);
    end
    check(errs == 0, req, first_act, first_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int hits;
    int stray;
    int ready_drops;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    check(dac_code == 8'd0, "R10 code after reset", dac_code, 0);
    check(buf_ready == 1'b1, "R10 ready after reset", buf_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(dac_code == 8'd0, "R10 idle active sample zero", dac_code, 0);

    // R7 ready falls after a write and R6 overwrite of the pending value
    mode_sel = 1'b1;
    period   = 16'd256;
    @(negedge clk);
    wr_data = 16'h1111;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(buf_ready == 1'b0, "R7 ready low after write", buf_ready, 0);
    write_sync(16'h4C60);
    check_pwm_window(16'h4C60, 256, 256, "R6 overwrite R4 pwm frame");
    check(buf_ready == 1'b1, "R7 ready high after transfer", buf_ready, 1);

    // R4 constrained-random PWM samples over full frames
    for (int k = 0; k < 6; k++) begin
      s = 16'($urandom);
      write_sync(s);
      check_pwm_window(s, 256, 512, "R4 pwm random sample");
    end

    // R3 zero fraction in PWM mode
    write_sync(16'h9A00);
    check_pwm_window(16'h9A00, 256, 256, "R3 pwm zero fraction");

    // R9 saturation in PWM mode
    write_sync(16'hFFC0);
    check_pwm_window(16'hFFC0, 256, 256, "R9 pwm saturate");

    // R5 short period truncates the frame
    period = 16'd32;
    write_sync(16'h200A);
    check_pwm_window(16'h200A, 32, 96, "R5 period 32 small fraction");
    write_sync(16'h70C8);
    check_pwm_window(16'h70C8, 32, 96, "R5 period 32 large fraction");

    // R2 random-mode duty and R1 output range
    mode_sel = 1'b0;
    period   = 16'd256;
    write_sync(16'h6440);
    hits = 0;
    stray = 0;
    for (int i = 0; i < 8192; i++) begin
      if (dac_code == 8'h65) hits++;
      else if (dac_code != 8'h64) stray++;
      @(negedge clk);
    end
    check(stray == 0, "R1 random code range", stray, 0);
    check(hits > 1648 && hits < 2448, "R2 random duty near 1/4", hits, 2048);

    // R1 range under random samples in random mode
    for (int k = 0; k < 4; k++) begin
      s = 16'($urandom);
      write_sync(s);
      stray = 0;
      for (int i = 0; i < 512; i++) begin
        if (dac_code != s[15:8] && dac_code != raised_of(s)) stray++;
        @(negedge clk);
      end
      check(stray == 0, "R1 random sample range", stray, 0);
    end

    // R3 and R9 in random mode
    write_sync(16'h3700);
    stray = 0;
    for (int i = 0; i < 512; i++) begin
      if (dac_code != 8'h37) stray++;
      @(negedge clk);
    end
    check(stray == 0, "R3 random zero fraction", stray, 0);
    write_sync(16'hFFFE);
    stray = 0;
    for (int i = 0; i < 512; i++) begin
      if (dac_code != 8'hFF) stray++;
      @(negedge clk);
    end
    check(stray == 0, "R9 random saturate", stray, 0);

    // R8 transparent buffering with period 1 and period 0
    for (int p = 0; p < 2; p++) begin
      period = 16'(1 - p);
      @(negedge clk);
      ready_drops = 0;
      for (int k = 0; k < 4; k++) begin
        s = {8'($urandom), 8'h00};
        wr_data = s;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (!buf_ready) ready_drops++;
        @(negedge clk);
        if (!buf_ready) ready_drops++;
        check(dac_code == s[15:8], "R8 transparent latency", dac_code, s[15:8]);
      end
      check(ready_drops == 0, "R8 ready stays high", ready_drops, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule